// File: doc/BRIEF.md
# Power-down wake-up sequencer

This block decides when a small microcontroller may leave its power-down state and when its core clock may run again. A power-down request from the running core stops the oscillator and gates the core clock. A falling edge on the active-low interrupt pin or on the active-low reset pin turns the oscillator back on. The core clock then stays gated until start-up is complete.

After an interrupt wake, start-up is complete either when a start-up timer expires or, in the pin-timed mode, when the interrupt pin returns high. The block then raises a wake-interrupt pending flag, which stays set until it is acknowledged. After a reset-pin wake, the timer always governs start-up. The core then gets either a fixed two-cycle internal reset or a reset held for as long as the pin stays low. The brown-out detector enable follows a configuration bit everywhere except in power-down.

Both pins pass through two-flop synchronizers and a falling-edge register, all running on the free-running oscillator clock.

Top module: `pd_wake_seq`

## Requirements
- R1: On release of rst_ni the block is running: osc_en_o=1, core_clk_en_o=1, core_rst_o=0, wake_irq_o=0.
- R2: pd_req_i high while running enters power-down on the next clock edge: osc_en_o=0 and core_clk_en_o=0.
- R3: In power-down, a falling edge on int_ni sets osc_en_o=1 on the third rising clock edge after the pin changes. With wake_ext_i=0, core_clk_en_o stays 0 for exactly the start-up timeout, counted in clock cycles.
- R4: With wake_ext_i=1, an interrupt wake keeps core_clk_en_o at 0 until the synchronized pin is high again, whatever the timer holds. If the pin stays low for L cycles, the gated interval is L cycles.
- R5: wake_irq_o is set on the cycle the core clock resumes after an interrupt wake. It stays set until irq_ack_i is sampled high.
- R6: A falling edge on rstpin_ni in power-down wakes the block and gates the clock for the timeout. If the pin is high again by then, core_rst_o is high for exactly 2 cycles with core_clk_en_o=1.
- R7: If rstpin_ni is still low at the timeout, core_rst_o stays high with the clock running. It drops on the third rising edge after the pin goes high.
- R8: sut_sel_i values 0, 1, 2 and 3 select timeouts of 16, 64, 256 and 1024 cycles. The value is sampled when the wake edge is taken.
- R9: bod_en_o equals bod_cfg_i whenever the block is not in power-down, and is 0 in power-down.
- R10: When reset and interrupt wake edges arrive in the same cycle, the reset path is taken and wake_irq_o stays 0.
- R11: Pin edges while running leave core_clk_en_o, osc_en_o and wake_irq_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| pd_req_i | input | 1 | Power-down request from the core |
| int_ni | input | 1 | Asynchronous active-low external interrupt pin |
| rstpin_ni | input | 1 | Asynchronous active-low reset pin |
| wake_ext_i | input | 1 | 1: interrupt pin length sets start-up; 0: timer sets it |
| sut_sel_i | input | 2 | Start-up timeout select |
| bod_cfg_i | input | 1 | Brown-out detector configuration bit |
| irq_ack_i | input | 1 | Clears the wake-interrupt pending flag |
| osc_en_o | output | 1 | Oscillator enable |
| core_clk_en_o | output | 1 | Core clock gate enable |
| core_rst_o | output | 1 | Internal core reset |
| wake_irq_o | output | 1 | Wake-interrupt pending flag |
| bod_en_o | output | 1 | Brown-out detector enable |

## Verification
The oscillator enable is due on the third rising edge after a wake pin falls: two synchronizer flops, then the state register. The gated interval that follows is exactly the timeout, or exactly the number of cycles the interrupt pin was held low. A held reset clears on the third edge after the pin rises. A scoreboard records, for each wake, the gated cycle count, the reset cycle count and the flag value expected from these rules. A monitor sampling on the falling clock edge measures each wake episode from the cycle the oscillator enable rises and compares the measured counts with the queued values. Direct checks use the same three-edge latency.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_PD,
    ST_INT_TMR,
    ST_INT_PIN,
    ST_RST_TMR,
    ST_RST_PULSE,
    ST_RST_HOLD
  } pdw_state_e;

  localparam int PIN_INT = 0;
  localparam int PIN_RST = 1;
  localparam int PIN_NUM = 2;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int   W      = 2,
  parameter int   STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
      else         sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/pdw_fall_det.sv
module pdw_fall_det #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/pdw_sut_timer.sv
module pdw_sut_timer #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 4,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);
  localparam int MAX_LOG2 = BASE_LOG2 + ((1 << SEL_W) - 1) * STEP_LOG2;
  localparam int CNT_W    = MAX_LOG2 + 1;

  logic [CNT_W-1:0] cnt_q, last_q;

  function automatic logic [CNT_W-1:0] last_of(input logic [SEL_W-1:0] s);
    int sh;
    sh = BASE_LOG2 + int'(s) * STEP_LOG2;
    return (CNT_W'(1) << sh) - CNT_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      last_q <= last_of(sel_i);
    end else if (run_i) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign done_o = run_i && (cnt_q == last_q);
endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl
  import pdw_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  input  logic int_fall_i,
  input  logic rst_fall_i,
  input  logic int_lvl_i,
  input  logic rst_lvl_i,
  input  logic wake_ext_i,
  input  logic tmr_done_i,
  input  logic irq_ack_i,
  output logic tmr_start_o,
  output logic tmr_run_o,
  output logic osc_en_o,
  output logic clk_en_o,
  output logic core_rst_o,
  output logic wake_irq_o
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  pdw_state_e       st_q, st_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             irq_q, irq_set;

  always_comb begin
    st_d        = st_q;
    pc_d        = pc_q;
    tmr_start_o = 1'b0;
    irq_set     = 1'b0;
    unique case (st_q)
      ST_RUN: if (pd_req_i) st_d = ST_PD;
      ST_PD: begin
        // reset edge wins over a simultaneous interrupt edge
        if (rst_fall_i) begin
          st_d        = ST_RST_TMR;
          tmr_start_o = 1'b1;
        end else if (int_fall_i) begin
          if (wake_ext_i) begin
            st_d = ST_INT_PIN;
          end else begin
            st_d        = ST_INT_TMR;
            tmr_start_o = 1'b1;
          end
        end
      end
      ST_INT_TMR: if (tmr_done_i) begin
        st_d    = ST_RUN;
        irq_set = 1'b1;
      end
      ST_INT_PIN: if (int_lvl_i) begin
        st_d    = ST_RUN;
        irq_set = 1'b1;
      end
      ST_RST_TMR: if (tmr_done_i) begin
        pc_d = '0;
        st_d = rst_lvl_i ? ST_RST_PULSE : ST_RST_HOLD;
      end
      ST_RST_PULSE: begin
        if (pc_q == PC_W'(PULSE_LEN - 1)) st_d = ST_RUN;
        else                              pc_d = pc_q + PC_W'(1);
      end
      ST_RST_HOLD: if (rst_lvl_i) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      pc_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
    end
  end

  assign tmr_run_o  = (st_q == ST_INT_TMR) || (st_q == ST_RST_TMR);
  assign osc_en_o   = (st_q != ST_PD);
  assign clk_en_o   = (st_q == ST_RUN) || (st_q == ST_RST_PULSE) || (st_q == ST_RST_HOLD);
  assign core_rst_o = (st_q == ST_RST_PULSE) || (st_q == ST_RST_HOLD);
  assign wake_irq_o = irq_q;
endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq
  import pdw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2,
  parameter int BASE_LOG2   = 4,
  parameter int STEP_LOG2   = 2,
  parameter int PULSE_LEN   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic             int_ni,
  input  logic             rstpin_ni,
  input  logic             wake_ext_i,
  input  logic [SEL_W-1:0] sut_sel_i,
  input  logic             bod_cfg_i,
  input  logic             irq_ack_i,
  output logic             osc_en_o,
  output logic             core_clk_en_o,
  output logic             core_rst_o,
  output logic             wake_irq_o,
  output logic             bod_en_o
);
  logic [PIN_NUM-1:0] pin_raw, pin_s, pin_fall;
  logic               tmr_start, tmr_run, tmr_done;

  assign pin_raw[PIN_INT] = int_ni;
  assign pin_raw[PIN_RST] = rstpin_ni;

  pdw_sync #(.W(PIN_NUM), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  pdw_fall_det #(.W(PIN_NUM)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_s),
    .fall_o(pin_fall)
  );

  pdw_sut_timer #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .run_i  (tmr_run),
    .sel_i  (sut_sel_i),
    .done_o (tmr_done)
  );

  pdw_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_req_i   (pd_req_i),
    .int_fall_i (pin_fall[PIN_INT]),
    .rst_fall_i (pin_fall[PIN_RST]),
    .int_lvl_i  (pin_s[PIN_INT]),
    .rst_lvl_i  (pin_s[PIN_RST]),
    .wake_ext_i (wake_ext_i),
    .tmr_done_i (tmr_done),
    .irq_ack_i  (irq_ack_i),
    .tmr_start_o(tmr_start),
    .tmr_run_o  (tmr_run),
    .osc_en_o   (osc_en_o),
    .clk_en_o   (core_clk_en_o),
    .core_rst_o (core_rst_o),
    .wake_irq_o (wake_irq_o)
  );

  assign bod_en_o = bod_cfg_i & osc_en_o;
endmodule

module pd_wake_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_ack_i,
  input logic bod_cfg_i,
  input logic osc_en_o,
  input logic core_clk_en_o,
  input logic core_rst_o,
  input logic wake_irq_o,
  input logic bod_en_o
);
  p_pd_clk_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !core_clk_en_o);

  p_wake_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !core_clk_en_o);

  p_irq_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o && !irq_ack_i |=> wake_irq_o);

  p_irq_at_resume_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_irq_o) |-> core_clk_en_o && !core_rst_o);

  p_rst_with_clk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> core_clk_en_o);

  p_rst_min_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |=> core_rst_o);

  p_bod_off_pd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !bod_en_o);
endmodule

bind pd_wake_seq pd_wake_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_ack_i    (irq_ack_i),
  .bod_cfg_i    (bod_cfg_i),
  .osc_en_o     (osc_en_o),
  .core_clk_en_o(core_clk_en_o),
  .core_rst_o   (core_rst_o),
  .wake_irq_o   (wake_irq_o),
  .bod_en_o     (bod_en_o)
);

// File: tb/pd_wake_seq_test.sv
`timescale 1ns/1ps
module pd_wake_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pd_req_i = 1'b0;
  logic       int_ni = 1'b1;
  logic       rstpin_ni = 1'b1;
  logic       wake_ext_i = 1'b0;
  logic [1:0] sut_sel_i = 2'd0;
  logic       bod_cfg_i = 1'b1;
  logic       irq_ack_i = 1'b0;
  logic       osc_en_o, core_clk_en_o, core_rst_o, wake_irq_o, bod_en_o;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;
  bit finished = 0;

  typedef struct packed {
    logic [15:0] gated;
    logic [15:0] rst_len;
    logic        irq;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk_i = ~clk_i;

  pd_wake_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_req_i(pd_req_i), .int_ni(int_ni),
    .rstpin_ni(rstpin_ni), .wake_ext_i(wake_ext_i), .sut_sel_i(sut_sel_i),
    .bod_cfg_i(bod_cfg_i), .irq_ack_i(irq_ack_i), .osc_en_o(osc_en_o),
    .core_clk_en_o(core_clk_en_o), .core_rst_o(core_rst_o),
    .wake_irq_o(wake_irq_o), .bod_en_o(bod_en_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: measures each wake episode
  int  phase = 0;
  int  g_cnt = 0;
  int  r_cnt = 0;
  bit  irq_seen = 0;
  bit  prev_osc = 1;

  task automatic close_episode();
    exp_t  e;
    string t;
    if (exp_q.size() == 0) begin
      chk("scoreboard_empty", 1, 0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " gated"}, g_cnt, int'(e.gated));
      chk({t, " rst_len"}, r_cnt, int'(e.rst_len));
      chk({t, " irq"}, int'(irq_seen), int'(e.irq));
    end
    phase = 0;
    done_cnt++;
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (phase == 0 && osc_en_o && !prev_osc) begin
        phase = 1;
        g_cnt = 0;
        r_cnt = 0;
      end
      if (phase == 1) begin
        if (!core_clk_en_o) g_cnt++;
        else begin
          irq_seen = wake_irq_o;
          if (core_rst_o) begin
            r_cnt = 1;
            phase = 2;
          end else close_episode();
        end
      end else if (phase == 2) begin
        if (core_rst_o) r_cnt++;
        else close_episode();
      end
      prev_osc = osc_en_o;
    end
  end

  task automatic push(input int g, input int r, input bit irq, input string tag);
    exp_t e;
    e.gated = 16'(g);
    e.rst_len = 16'(r);
    e.irq = irq;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wait_done();
    int d = done_cnt;
    while (done_cnt == d) @(negedge clk_i);
  endtask

  task automatic enter_pd();
    @(negedge clk_i) pd_req_i = 1'b1;
    @(negedge clk_i) pd_req_i = 1'b0;
    chk("R2 osc_en in pd", int'(osc_en_o), 0);
    chk("R2 clk_en in pd", int'(core_clk_en_o), 0);
    chk("R9 bod_en in pd", int'(bod_en_o), 0);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic ack_irq();
    repeat (3) @(negedge clk_i);
    chk("R5 flag held", int'(wake_irq_o), 1);
    irq_ack_i = 1'b1;
    @(negedge clk_i) irq_ack_i = 1'b0;
    chk("R5 flag cleared", int'(wake_irq_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 osc_en", int'(osc_en_o), 1);
    chk("R1 clk_en", int'(core_clk_en_o), 1);
    chk("R1 core_rst", int'(core_rst_o), 0);
    chk("R1 wake_irq", int'(wake_irq_o), 0);
    chk("R9 bod_en run", int'(bod_en_o), 1);

    // R11: edges while running are ignored
    int_ni = 1'b0;
    rstpin_ni = 1'b0;
    repeat (6) @(negedge clk_i);
    chk("R11 clk_en", int'(core_clk_en_o), 1);
    chk("R11 osc_en", int'(osc_en_o), 1);
    chk("R11 wake_irq", int'(wake_irq_o), 0);
    int_ni = 1'b1;
    rstpin_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R3: timer wake, osc latency 3 edges
    sut_sel_i = 2'd0;
    enter_pd();
    push(16, 0, 1'b1, "R3");
    int_ni = 1'b0;
    @(negedge clk_i) chk("R3 osc after 1", int'(osc_en_o), 0);
    @(negedge clk_i) chk("R3 osc after 2", int'(osc_en_o), 0);
    @(negedge clk_i) chk("R3 osc after 3", int'(osc_en_o), 1);
    int_ni = 1'b1;
    wait_done();
    ack_irq();

    // R8: other timeout selections
    sut_sel_i = 2'd1;
    enter_pd();
    push(64, 0, 1'b1, "R8 sel1");
    int_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    int_ni = 1'b1;
    wait_done();
    ack_irq();

    sut_sel_i = 2'd2;
    enter_pd();
    push(256, 0, 1'b1, "R8 sel2");
    int_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    int_ni = 1'b1;
    wait_done();
    ack_irq();

    // R6 + R8: reset wake, early release, longest timeout
    sut_sel_i = 2'd3;
    enter_pd();
    push(1024, 2, 1'b0, "R6 sel3");
    rstpin_ni = 1'b0;
    repeat (5) @(negedge clk_i);
    rstpin_ni = 1'b1;
    wait_done();

    // R4: pin-timed wake, pin held longer than the timer
    sut_sel_i = 2'd0;
    wake_ext_i = 1'b1;
    enter_pd();
    push(100, 0, 1'b1, "R4");
    int_ni = 1'b0;
    repeat (100) @(negedge clk_i);
    int_ni = 1'b1;
    wait_done();
    ack_irq();
    wake_ext_i = 1'b0;

    // R6: reset wake, short timeout
    enter_pd();
    push(16, 2, 1'b0, "R6");
    rstpin_ni = 1'b0;
    repeat (5) @(negedge clk_i);
    rstpin_ni = 1'b1;
    wait_done();

    // R7: reset held past timeout; clears 3 edges after release
    enter_pd();
    push(16, 8, 1'b0, "R7");
    rstpin_ni = 1'b0;
    do @(negedge clk_i); while (!core_clk_en_o);
    repeat (5) @(negedge clk_i);
    rstpin_ni = 1'b1;
    wait_done();

    // R10: simultaneous edges, reset wins
    enter_pd();
    push(16, 2, 1'b0, "R10");
    rstpin_ni = 1'b0;
    int_ni = 1'b0;
    repeat (5) @(negedge clk_i);
    rstpin_ni = 1'b1;
    wait_done();
    repeat (3) @(negedge clk_i);
    chk("R10 no flag", int'(wake_irq_o), 0);
    int_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R9: configuration bit off
    bod_cfg_i = 1'b0;
    @(negedge clk_i) chk("R9 bod_en cfg0", int'(bod_en_o), 0);
    bod_cfg_i = 1'b1;
    @(negedge clk_i) chk("R9 bod_en cfg1", int'(bod_en_o), 1);

    chk("scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule